// File: doc/BRIEF.md
# Halt, Wake-up and Reset Sequencer

This block sits beside the processor core of a small microcontroller and controls when the core may run. A halt command from the core gates the system oscillator off and parks the core. The block then waits for one of four wake causes: an external reset, a watchdog overflow, a new interrupt request, or a falling edge on an enabled pin of the 8-bit wake port. Every wake and every system reset is followed by a fixed start-up stall. This gives the oscillator time to settle before the core is released.

Two status bits, the time-out flag and the power-down flag, keep a record of the cause. Software can read them after restart and tell the five reset and wake cases apart. A watchdog overflow while halted gives only a warm restart, which clears the program counter and stack pointer. An external reset, or a watchdog overflow in normal run, gives a full initialization. A full initialization also inserts a short configuration-load phase before the stall. When the core is released after an interrupt or port wake, a one-cycle pulse tells it whether to enter the interrupt response or to continue at the next instruction.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: After power-on reset, TO=0 and PDF=0, `full_rst_o` is high for the 16-cycle configuration phase, and `core_run_o` first reads high exactly 16+1024 cycles after reset is released.
- R2: A halt command while running sets PDF=1 and TO=0. On the next cycle it drops `osc_en_o` and `core_run_o` and gives a one-cycle `wdt_clr_o` pulse.
- R3: A clear-watchdog command while running sets PDF=0, leaves TO unchanged and gives a one-cycle `wdt_clr_o` pulse.
- R4: While running, an external reset leaves TO and PDF unchanged. A watchdog overflow sets TO=1 and leaves PDF unchanged. Both give a full reset: 16 configuration cycles, then 1024 stall cycles.
- R5: An external reset while halted gives TO=0, PDF=1 and the same full reset sequence.
- R6: A watchdog overflow while halted gives TO=1 and PDF=1 and one `warm_rst_o` pulse. It gives no full reset and no configuration phase, only the 1024-cycle stall, and no take/resume pulse.
- R7: While halted, a falling edge on a wake-port bit whose enable is 1 wakes the block with a `resume_o` pulse. The edge is seen after a 2-flop synchronizer plus a compare stage, so the stall starts 2 cycles after the pin falls. Edges on bits whose enable is 0, and rising edges, have no effect.
- R8: While halted, a new interrupt request wakes the block. `irq_take_o` pulses if that request is enabled and the stack is not full; otherwise `resume_o` pulses. Exactly one of the two pulses appears, in the cycle `core_run_o` rises.
- R9: A request bit already set when halt is entered does not wake the block. Once it clears, a later rise on that bit does wake it.
- R10: After each wake, `core_run_o` stays low for exactly 1024 cycles, with the oscillator running, before it rises.
- R11: An external reset during the configuration or stall phase restarts the full 16+1024 sequence.
- R12: Wake causes in the same cycle are ranked: external reset first, then watchdog overflow, then interrupt, then port edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running control clock, alive during halt |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| halt_i | input | 1 | Halt command pulse from the core |
| clr_wdt_i | input | 1 | Clear-watchdog command pulse from the core |
| ext_rst_i | input | 1 | Synchronized external reset request |
| wdt_ovf_i | input | 1 | Watchdog overflow pulse |
| port_i | input | PORT_W | Raw wake-port pins |
| port_wake_en_i | input | PORT_W | Per-pin wake enable |
| irq_req_i | input | NUM_IRQ | Interrupt request flags |
| irq_en_i | input | NUM_IRQ | Interrupt enables |
| stack_full_i | input | 1 | Core call stack is full |
| osc_en_o | output | 1 | System oscillator enable |
| core_run_o | output | 1 | Core may execute (low = stalled) |
| full_rst_o | output | 1 | Full initialization, high during configuration phase |
| warm_rst_o | output | 1 | One-cycle clear of program counter and stack pointer |
| wdt_clr_o | output | 1 | One-cycle watchdog and prescaler clear |
| irq_take_o | output | 1 | One-cycle pulse: enter interrupt response on release |
| resume_o | output | 1 | One-cycle pulse: continue at next instruction on release |
| to_o | output | 1 | Time-out flag |
| pdf_o | output | 1 | Power-down flag |

## Verification
The checks assume that every input is synchronous to `clk` except the wake-port pins. They also assume that halt, clear-watchdog and watchdog overflow arrive as single-cycle pulses, and that the watchdog counter has no meaningful overflow in the same cycle as a halt. The bench changes inputs only on the falling edge and holds each command for one rising edge. It issues halt only after `core_run_o` is seen high. The port pins are the one asynchronous input; they are driven low and held until the core is released, so the synchronizer always sees a stable level.

// File: rtl/pwk_pkg.sv
package pwk_pkg;

    typedef enum logic [1:0] {
        ST_CFG   = 2'd0,
        ST_STALL = 2'd1,
        ST_RUN   = 2'd2,
        ST_HALT  = 2'd3
    } pwk_state_e;

    typedef enum logic [1:0] {
        WK_NONE   = 2'd0,
        WK_RESUME = 2'd1,
        WK_TAKE   = 2'd2
    } pwk_kind_e;

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_EXT  = 3'd1,
        SRC_WDT  = 3'd2,
        SRC_IRQ  = 3'd3,
        SRC_PORT = 3'd4
    } pwk_src_e;

endpackage

// File: rtl/pwk_edge_det.sv
module pwk_edge_det #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] fall_o
);
    // per-pin: two synchronizer stages and one history stage
    for (genvar b = 0; b < W; b++) begin : g_pin
        logic s1_q, s2_q, prev_q;
        logic s1_d, s2_d, prev_d;

        always_comb begin
            s1_d   = pin_i[b];
            s2_d   = s1_q;
            prev_d = s2_q;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q   <= 1'b0;
                s2_q   <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                s1_q   <= s1_d;
                s2_q   <= s2_d;
                prev_q <= prev_d;
            end
        end

        assign fall_o[b] = prev_q & ~s2_q;
    end
endmodule

// File: rtl/pwk_wake_arb.sv
module pwk_wake_arb
    import pwk_pkg::*;
#(
    parameter int NIRQ = 4,
    parameter int PW   = 8
) (
    input  logic            ext_i,
    input  logic            wdt_i,
    input  logic [NIRQ-1:0] irq_new_i,
    input  logic [NIRQ-1:0] irq_en_i,
    input  logic            stack_full_i,
    input  logic [PW-1:0]   fall_i,
    input  logic [PW-1:0]   port_en_i,
    output pwk_src_e        src_o,
    output logic            take_o
);
    always_comb begin
        if (ext_i)                       src_o = SRC_EXT;
        else if (wdt_i)                  src_o = SRC_WDT;
        else if (|irq_new_i)             src_o = SRC_IRQ;
        else if (|(fall_i & port_en_i))  src_o = SRC_PORT;
        else                             src_o = SRC_NONE;
        take_o = (|(irq_new_i & irq_en_i)) && !stack_full_i;
    end
endmodule

// File: rtl/pwk_timer.sv
module pwk_timer #(
    parameter int          CW      = 11,
    parameter logic [CW-1:0] RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] val_i,
    output logic          done_o
);
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)            cnt_d = val_i;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= RST_VAL;
        else        cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == '0);
endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
    import pwk_pkg::*;
#(
    parameter int PORT_W    = 8,
    parameter int NUM_IRQ   = 4,
    parameter int STALL_CYC = 1024,
    parameter int CFG_CYC   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               halt_i,
    input  logic               clr_wdt_i,
    input  logic               ext_rst_i,
    input  logic               wdt_ovf_i,
    input  logic [PORT_W-1:0]  port_i,
    input  logic [PORT_W-1:0]  port_wake_en_i,
    input  logic [NUM_IRQ-1:0] irq_req_i,
    input  logic [NUM_IRQ-1:0] irq_en_i,
    input  logic               stack_full_i,
    output logic               osc_en_o,
    output logic               core_run_o,
    output logic               full_rst_o,
    output logic               warm_rst_o,
    output logic               wdt_clr_o,
    output logic               irq_take_o,
    output logic               resume_o,
    output logic               to_o,
    output logic               pdf_o
);
    localparam int CNT_W = $clog2(STALL_CYC) + 1;
    localparam logic [CNT_W-1:0] STALL_LD = CNT_W'(STALL_CYC - 1);
    localparam logic [CNT_W-1:0] CFG_LD   = CNT_W'(CFG_CYC - 1);

    typedef struct packed {
        pwk_state_e         st;
        pwk_kind_e          kind;
        logic               to;
        logic               pdf;
        logic [NUM_IRQ-1:0] pend;
        logic               warm;
        logic               wclr;
        logic               take;
        logic               res;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        st: ST_CFG, kind: WK_NONE, to: 1'b0, pdf: 1'b0, pend: '0,
        warm: 1'b0, wclr: 1'b0, take: 1'b0, res: 1'b0
    };

    ctl_t               cur_q, nxt_d;
    logic               tmr_load;
    logic [CNT_W-1:0]   tmr_val;
    logic               tmr_done;
    logic [PORT_W-1:0]  port_fall;
    logic [NUM_IRQ-1:0] irq_new;
    pwk_src_e           wake_src;
    logic               wake_take;

    pwk_edge_det #(.W(PORT_W)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (port_i),
        .fall_o (port_fall)
    );

    assign irq_new = irq_req_i & ~cur_q.pend;

    pwk_wake_arb #(.NIRQ(NUM_IRQ), .PW(PORT_W)) u_arb (
        .ext_i        (ext_rst_i),
        .wdt_i        (wdt_ovf_i),
        .irq_new_i    (irq_new),
        .irq_en_i     (irq_en_i),
        .stack_full_i (stack_full_i),
        .fall_i       (port_fall),
        .port_en_i    (port_wake_en_i),
        .src_o        (wake_src),
        .take_o       (wake_take)
    );

    pwk_timer #(.CW(CNT_W), .RST_VAL(CFG_LD)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .done_o (tmr_done)
    );

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.warm = 1'b0;
        nxt_d.wclr = 1'b0;
        nxt_d.take = 1'b0;
        nxt_d.res  = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = CFG_LD;

        unique case (cur_q.st)
            ST_CFG, ST_STALL: begin
                if (ext_rst_i) begin
                    nxt_d.st = ST_CFG;
                    tmr_load = 1'b1;
                end else if (wdt_ovf_i) begin
                    nxt_d.st = ST_CFG;
                    nxt_d.to = 1'b1;
                    tmr_load = 1'b1;
                end else if (tmr_done) begin
                    if (cur_q.st == ST_CFG) begin
                        nxt_d.st = ST_STALL;
                        tmr_load = 1'b1;
                        tmr_val  = STALL_LD;
                    end else begin
                        nxt_d.st   = ST_RUN;
                        nxt_d.take = (cur_q.kind == WK_TAKE);
                        nxt_d.res  = (cur_q.kind == WK_RESUME);
                        nxt_d.kind = WK_NONE;
                    end
                end
            end
            ST_RUN: begin
                if (ext_rst_i) begin
                    nxt_d.st = ST_CFG;
                    tmr_load = 1'b1;
                end else if (wdt_ovf_i) begin
                    nxt_d.st = ST_CFG;
                    nxt_d.to = 1'b1;
                    tmr_load = 1'b1;
                end else if (halt_i) begin
                    nxt_d.st   = ST_HALT;
                    nxt_d.pdf  = 1'b1;
                    nxt_d.to   = 1'b0;
                    nxt_d.wclr = 1'b1;
                    nxt_d.pend = irq_req_i;
                end else if (clr_wdt_i) begin
                    nxt_d.pdf  = 1'b0;
                    nxt_d.wclr = 1'b1;
                end
            end
            ST_HALT: begin
                nxt_d.pend = cur_q.pend & irq_req_i;
                unique case (wake_src)
                    SRC_EXT: begin
                        nxt_d.st  = ST_CFG;
                        nxt_d.to  = 1'b0;
                        nxt_d.pdf = 1'b1;
                        tmr_load  = 1'b1;
                    end
                    SRC_WDT: begin
                        nxt_d.st   = ST_STALL;
                        nxt_d.to   = 1'b1;
                        nxt_d.pdf  = 1'b1;
                        nxt_d.warm = 1'b1;
                        nxt_d.kind = WK_NONE;
                        tmr_load   = 1'b1;
                        tmr_val    = STALL_LD;
                    end
                    SRC_IRQ: begin
                        nxt_d.st   = ST_STALL;
                        nxt_d.kind = wake_take ? WK_TAKE : WK_RESUME;
                        tmr_load   = 1'b1;
                        tmr_val    = STALL_LD;
                    end
                    SRC_PORT: begin
                        nxt_d.st   = ST_STALL;
                        nxt_d.kind = WK_RESUME;
                        tmr_load   = 1'b1;
                        tmr_val    = STALL_LD;
                    end
                    default: ;
                endcase
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= CTL_RST;
        else        cur_q <= nxt_d;
    end

    assign osc_en_o   = (cur_q.st != ST_HALT);
    assign core_run_o = (cur_q.st == ST_RUN);
    assign full_rst_o = (cur_q.st == ST_CFG);
    assign warm_rst_o = cur_q.warm;
    assign wdt_clr_o  = cur_q.wclr;
    assign irq_take_o = cur_q.take;
    assign resume_o   = cur_q.res;
    assign to_o       = cur_q.to;
    assign pdf_o      = cur_q.pdf;
endmodule

// File: rtl/pwk_checker.sv
module pwk_checker #(
    parameter int STALL_CYC = 1024
) (
    input logic clk,
    input logic rst_n,
    input logic osc_en_o,
    input logic core_run_o,
    input logic full_rst_o,
    input logic warm_rst_o,
    input logic wdt_clr_o,
    input logic irq_take_o,
    input logic resume_o,
    input logic to_o,
    input logic pdf_o
);
    localparam int SW = $clog2(STALL_CYC) + 2;
    localparam logic [SW-1:0] SMAX = '1;

    logic [SW-1:0] stall_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                      stall_q <= '0;
        else if (core_run_o || full_rst_o || !osc_en_o)  stall_q <= '0;
        else if (stall_q != SMAX)                        stall_q <= stall_q + 1'b1;
    end

    AST_CFG_HOLDS_CORE: assert property (@(posedge clk) disable iff (!rst_n)
        full_rst_o |-> !core_run_o);                                          // R1
    AST_HALT_HOLDS_CORE: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en_o |-> !core_run_o);                                           // R2
    AST_HALT_ENTRY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_en_o) |-> (pdf_o && !to_o && wdt_clr_o));                   // R2
    AST_WARM_FROM_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        warm_rst_o |-> (to_o && pdf_o && !full_rst_o && $past(!osc_en_o)));   // R6
    AST_ONE_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_take_o && resume_o));                                           // R8
    AST_DECISION_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take_o || resume_o) |-> $rose(core_run_o));                      // R8
    AST_STALL_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_run_o) |-> (stall_q == SW'(STALL_CYC)));                   // R10
endmodule

bind pwr_wake_ctrl pwk_checker #(.STALL_CYC(STALL_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .osc_en_o   (osc_en_o),
    .core_run_o (core_run_o),
    .full_rst_o (full_rst_o),
    .warm_rst_o (warm_rst_o),
    .wdt_clr_o  (wdt_clr_o),
    .irq_take_o (irq_take_o),
    .resume_o   (resume_o),
    .to_o       (to_o),
    .pdf_o      (pdf_o)
);

// File: tb/sim_pwr_wake_ctrl.sv
module sim_pwr_wake_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int STALL = 1024;
    localparam int CFG   = 16;
    localparam int PW    = 8;
    localparam int NI    = 4;

    logic clk = 1'b0;
    logic rst_n, halt, clr_wdt, ext_rst, wdt_ovf, sf;
    logic [PW-1:0] port, port_en;
    logic [NI-1:0] irq, irq_en;
    logic osc_en, core_run, full_rst, warm_rst, wdt_clr, take, res, to, pdf;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_wake_ctrl #(.PORT_W(PW), .NUM_IRQ(NI), .STALL_CYC(STALL), .CFG_CYC(CFG)) u0 (
        .clk(clk), .rst_n(rst_n), .halt_i(halt), .clr_wdt_i(clr_wdt),
        .ext_rst_i(ext_rst), .wdt_ovf_i(wdt_ovf), .port_i(port),
        .port_wake_en_i(port_en), .irq_req_i(irq), .irq_en_i(irq_en),
        .stack_full_i(sf), .osc_en_o(osc_en), .core_run_o(core_run),
        .full_rst_o(full_rst), .warm_rst_o(warm_rst), .wdt_clr_o(wdt_clr),
        .irq_take_o(take), .resume_o(res), .to_o(to), .pdf_o(pdf)
    );

    // ev codes: 0 ext reset, 1 watchdog, 2 port bit3 fall, 3 irq0 (enabled),
    // 4 irq1 (disabled), 5 irq0 with stack full, 6 watchdog+irq0, 7 ext+watchdog
    // tk: 0 = full reset path, 1 = stall only, 2 = stall after port latency
    typedef struct packed {
        logic       hlt;
        logic [3:0] ev;
        logic       to;
        logic       pdf;
        logic [1:0] tk;
        logic       take;
        logic       res;
        logic       warm;
        logic       full;
    } row_t;

    localparam int NROW = 9;
    localparam row_t TBL [NROW] = '{
        '{hlt:1'b0, ev:4'd1, to:1'b1, pdf:1'b0, tk:2'd0, take:1'b0, res:1'b0, warm:1'b0, full:1'b1},
        '{hlt:1'b0, ev:4'd0, to:1'b1, pdf:1'b0, tk:2'd0, take:1'b0, res:1'b0, warm:1'b0, full:1'b1},
        '{hlt:1'b1, ev:4'd0, to:1'b0, pdf:1'b1, tk:2'd0, take:1'b0, res:1'b0, warm:1'b0, full:1'b1},
        '{hlt:1'b1, ev:4'd1, to:1'b1, pdf:1'b1, tk:2'd1, take:1'b0, res:1'b0, warm:1'b1, full:1'b0},
        '{hlt:1'b1, ev:4'd2, to:1'b0, pdf:1'b1, tk:2'd2, take:1'b0, res:1'b1, warm:1'b0, full:1'b0},
        '{hlt:1'b1, ev:4'd3, to:1'b0, pdf:1'b1, tk:2'd1, take:1'b1, res:1'b0, warm:1'b0, full:1'b0},
        '{hlt:1'b1, ev:4'd4, to:1'b0, pdf:1'b1, tk:2'd1, take:1'b0, res:1'b1, warm:1'b0, full:1'b0},
        '{hlt:1'b1, ev:4'd5, to:1'b0, pdf:1'b1, tk:2'd1, take:1'b0, res:1'b1, warm:1'b0, full:1'b0},
        '{hlt:1'b0, ev:4'd0, to:1'b0, pdf:1'b1, tk:2'd0, take:1'b0, res:1'b0, warm:1'b0, full:1'b1}
    };

    int errors = 0;
    int checks = 0;
    int n_cyc;
    logic sw_warm, sw_full, sw_take, sw_res;

    function automatic string row_tag(input int i);
        case (i)
            2:       return "R5";
            3:       return "R6";
            4:       return "R7";
            5, 6, 7: return "R8";
            default: return "R4";
        endcase
    endfunction

    function automatic int exp_cycles(input logic [1:0] tk);
        case (tk)
            2'd0:    return CFG + STALL + 1;
            2'd1:    return STALL + 1;
            default: return STALL + 3;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic go_halt();
        repeat (4) @(negedge clk);
        halt = 1'b1;
        @(negedge clk);
        halt = 1'b0;
    endtask

    task automatic run_ev(input int ev);
        @(negedge clk);
        case (ev)
            0: ext_rst = 1'b1;
            1: wdt_ovf = 1'b1;
            2: port[3] = 1'b0;
            3: irq[0] = 1'b1;
            4: irq[1] = 1'b1;
            5: begin irq[0] = 1'b1; sf = 1'b1; end
            6: begin wdt_ovf = 1'b1; irq[0] = 1'b1; end
            7: begin ext_rst = 1'b1; wdt_ovf = 1'b1; end
            default: ;
        endcase
        n_cyc = 0;
        sw_warm = 1'b0; sw_full = 1'b0; sw_take = 1'b0; sw_res = 1'b0;
        do begin
            @(posedge clk);
            n_cyc++;
            @(negedge clk);
            ext_rst = 1'b0;
            wdt_ovf = 1'b0;
            sw_warm |= warm_rst;
            sw_full |= full_rst;
            sw_take |= take;
            sw_res  |= res;
        end while (!core_run && n_cyc < 5000);
        irq  = '0;
        sf   = 1'b0;
        port = '1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; halt = 1'b0; clr_wdt = 1'b0; ext_rst = 1'b0; wdt_ovf = 1'b0;
        sf = 1'b0; port = '1; port_en = 8'b0000_1000; irq = '0; irq_en = 4'b0001;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk("R1 reset core_run", int'(core_run), 0);
        chk("R1 reset full_rst", int'(full_rst), 1);
        chk("R1 reset osc_en", int'(osc_en), 1);
        chk("R1 reset to/pdf", int'({to, pdf}), 0);
        rst_n = 1'b1;
        n_cyc = 0;
        do begin
            @(posedge clk);
            n_cyc++;
            @(negedge clk);
        end while (!core_run && n_cyc < 5000);
        chk("R1 power-up release cycles", n_cyc, CFG + STALL);

        // vector table
        for (int i = 0; i < NROW; i++) begin
            if (TBL[i].hlt) go_halt();
            run_ev(int'(TBL[i].ev));
            chk($sformatf("%s/R10 row%0d cycles", row_tag(i), i), n_cyc, exp_cycles(TBL[i].tk));
            chk($sformatf("%s row%0d to", row_tag(i), i), int'(to), int'(TBL[i].to));
            chk($sformatf("%s row%0d pdf", row_tag(i), i), int'(pdf), int'(TBL[i].pdf));
            chk($sformatf("%s row%0d take", row_tag(i), i), int'(sw_take), int'(TBL[i].take));
            chk($sformatf("%s row%0d resume", row_tag(i), i), int'(sw_res), int'(TBL[i].res));
            chk($sformatf("%s row%0d warm", row_tag(i), i), int'(sw_warm), int'(TBL[i].warm));
            chk($sformatf("%s row%0d full", row_tag(i), i), int'(sw_full), int'(TBL[i].full));
        end

        // R2 halt entry outputs
        go_halt();
        chk("R2 halt wdt_clr pulse", int'(wdt_clr), 1);
        chk("R2 halt osc_en", int'(osc_en), 0);
        chk("R2 halt core_run", int'(core_run), 0);
        chk("R2 halt to/pdf", int'({to, pdf}), 1);
        @(negedge clk);
        chk("R2 wdt_clr one cycle", int'(wdt_clr), 0);
        run_ev(2);
        chk("R7 port wake resume", int'(sw_res), 1);

        // R3 clear-watchdog with TO set
        run_ev(1);
        chk("R4 run watchdog to/pdf", int'({to, pdf}), 3);
        @(negedge clk);
        clr_wdt = 1'b1;
        @(negedge clk);
        clr_wdt = 1'b0;
        chk("R3 clr wdt_clr pulse", int'(wdt_clr), 1);
        chk("R3 clr pdf", int'(pdf), 0);
        chk("R3 clr to unchanged", int'(to), 1);

        // R9 pending request and R7 disabled pin do not wake
        @(negedge clk);
        irq[0] = 1'b1;
        go_halt();
        @(negedge clk);
        port[5] = 1'b0;
        repeat (20) @(negedge clk);
        chk("R9 pending irq no wake", int'(osc_en), 0);
        chk("R7 disabled pin no wake", int'(core_run), 0);
        irq  = '0;
        port = '1;
        repeat (4) @(negedge clk);
        chk("R7 rising edge no wake", int'(osc_en), 0);
        run_ev(3);
        chk("R9 re-raised irq wakes cycles", n_cyc, STALL + 1);
        chk("R9 re-raised irq take", int'(sw_take), 1);

        // R12 priority
        go_halt();
        run_ev(6);
        chk("R12 wdt over irq warm", int'(sw_warm), 1);
        chk("R12 wdt over irq take", int'(sw_take), 0);
        chk("R12 wdt over irq to", int'(to), 1);
        go_halt();
        run_ev(7);
        chk("R12 ext over wdt full", int'(sw_full), 1);
        chk("R12 ext over wdt warm", int'(sw_warm), 0);
        chk("R12 ext over wdt to/pdf", int'({to, pdf}), 1);
        chk("R12 ext over wdt cycles", n_cyc, CFG + STALL + 1);

        // R11 reset mid-stall restarts sequence
        @(negedge clk);
        ext_rst = 1'b1;
        @(negedge clk);
        ext_rst = 1'b0;
        repeat (600) @(negedge clk);
        chk("R11 still stalled", int'(core_run), 0);
        run_ev(0);
        chk("R11 restart cycles", n_cyc, CFG + STALL + 1);
        chk("R11 flags unchanged", int'({to, pdf}), 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule